// File: doc/BRIEF.md
# JTAG Test Access Port with In-System-Programming Command Gating

This block is a four-wire boundary-scan test access port (TCK, TMS, TDI, TDO) with no dedicated test-reset pin. It holds the sixteen-state TAP controller, a 4-bit instruction register, a one-bit bypass stage, a 32-bit identification register and a parameterised programming shift register. The controller returns to Test-Logic-Reset from a power-up reset or from five TCK edges with TMS high.

Four programming instructions use the programming shift register: an arming instruction and three array actions (erase, program and verify). An action is honoured only after the arming instruction has been loaded. Arming then stays in force across later instructions until the controller passes through Test-Logic-Reset. An honoured action sends a one-cycle request strobe to an external array controller. A program request hands over the shift register contents as row data. For a verify, row data returned by the array is loaded into the shift register in Capture-DR, so it can be shifted out. The block drives TDO on falling TCK edges and drives a separate output-enable for an external tristate pad.

Top module: `tap_isp_port`

## Requirements
- R1: While `por_n` is low and after it is released, the controller is in Test-Logic-Reset, the active instruction is the identification code 0001, arming is clear, every request strobe is low and `tdo_oe` is low.
- R2: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. That state reloads instruction 0001 and clears arming.
- R3: Capture-IR loads binary 0001 into the instruction shift stage. Bits shift in from TDI and out on TDO least significant bit first. The new instruction takes effect in Update-IR.
- R4: Instruction 0001 puts the 32-bit identification register between TDI and TDO. Capture-DR loads the `ID_VALUE` parameter into it, and it shifts out least significant bit first.
- R5: Instruction 1111, and every code other than 0001, 1001, 1010, 1011 and 1100, selects the one-bit bypass stage. The stage captures 0, and TDO repeats TDI one shift later.
- R6: TDI is sampled on rising TCK. TDO and `tdo_oe` change on falling TCK. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R7: Codes 1001 (arm), 1010 (erase), 1011 (program) and 1100 (verify) select the `ROW_W`-bit programming shift register. It shifts least significant bit first, and its contents are always present on `row_wdata`.
- R8: Loading 1001 sets arming. Arming persists through any later instructions until Test-Logic-Reset.
- R9: While armed, loading 1010, 1011 or 1100 raises `erase_req`, `prog_req` or `verify_req` respectively for exactly one TCK cycle. The strobe is registered on the first rising edge in Run-Test/Idle entered directly from Update-IR. If Update-IR exits to Select-DR-Scan, no strobe is raised.
- R10: Without arming, no instruction raises any request strobe.
- R11: With 1100 active and arming set, Capture-DR loads `row_rdata` into the programming shift register. With any other programming code, or without arming, Capture-DR leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous active-low power-up reset |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Drive enable for the external TDO pad |
| row_rdata | input | ROW_W | Row data returned by the array for a verify |
| row_wdata | output | ROW_W | Programming shift register contents sent to the array |
| erase_req | output | 1 | One-cycle erase request |
| prog_req | output | 1 | One-cycle program request |
| verify_req | output | 1 | One-cycle verify request |

## Verification
Assertions check, on every TCK edge, the following properties:
- Request strobes are mutually exclusive, last one cycle, follow a Run-Test/Idle cycle and only occur while armed.
- Test-Logic-Reset clears arming.
- Five TMS-high edges always land in Test-Logic-Reset.
- `tdo_oe` is confined to the shift states.
- A verify capture loads the returned row data, while other programming captures hold the register.

The bench scenarios cover the rest:
- Serial ordering of the identification, bypass and programming paths.
- The sweep of all sixteen instruction codes both unarmed and armed.
- Arming persisting across instructions until a TMS reset or power-up reset.
- The suppressed strobe when Update-IR leaves through Select-DR-Scan.

// File: rtl/tap_isp_pkg.sv
package tap_isp_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] OP_ARM     = 4'b1001;
  localparam logic [IR_W-1:0] OP_ERASE   = 4'b1010;
  localparam logic [IR_W-1:0] OP_PROG    = 4'b1011;
  localparam logic [IR_W-1:0] OP_VERIFY  = 4'b1100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_ISP} dr_sel_e;

  function automatic dr_sel_e op_to_sel(input logic [IR_W-1:0] op);
    dr_sel_e s;
    case (op)
      OP_IDCODE:                              s = SEL_ID;
      OP_ARM, OP_ERASE, OP_PROG, OP_VERIFY:   s = SEL_ISP;
      default:                                s = SEL_BYP;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_isp_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

  // Checker: run of consecutive TMS-high edges, saturating at five.
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                 hi_run <= '0;
    else if (!tms)              hi_run <= '0;
    else if (hi_run != 3'd5)    hi_run <= hi_run + 3'd1;
  end

  p_tms_escape_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_isp_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb,
  output logic            armed_q,
  output logic [2:0]      req_q      // {verify, program, erase}
);

  logic [IR_W-1:0] ir_sr;
  logic [2:0]      pend_q;
  logic [2:0]      act_d;
  logic            upd_ir;

  assign upd_ir = (state == ST_UPD_IR);
  assign ir_lsb = ir_sr[0];

  always_comb begin
    act_d = 3'b000;
    if (armed_q) begin
      case (ir_sr)
        OP_ERASE:  act_d = 3'b001;
        OP_PROG:   act_d = 3'b010;
        OP_VERIFY: act_d = 3'b100;
        default:   act_d = 3'b000;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr   <= IR_CAPTURE;
      ir_q    <= OP_IDCODE;
      armed_q <= 1'b0;
      pend_q  <= 3'b000;
      req_q   <= 3'b000;
    end else begin
      if (state == ST_CAP_IR)     ir_sr <= IR_CAPTURE;
      else if (state == ST_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

      if (state == ST_RESET)      ir_q <= OP_IDCODE;
      else if (upd_ir)            ir_q <= ir_sr;

      if (state == ST_RESET)                armed_q <= 1'b0;
      else if (upd_ir && ir_sr == OP_ARM)   armed_q <= 1'b1;

      pend_q <= upd_ir ? act_d : 3'b000;
      req_q  <= (state == ST_IDLE) ? pend_q : 3'b000;
    end
  end

  p_strobe_onehot_r9: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0(req_q));
  p_strobe_after_idle_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (|req_q) |-> ($past(state) == ST_IDLE));
  p_strobe_single_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (|req_q) |=> (req_q == 3'b000));
  p_strobe_needs_arm_r10: assert property (@(posedge tck) disable iff (!rst_n)
    (|req_q) |-> armed_q);
  p_reset_disarms_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> !armed_q);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_isp_pkg::*;
#(
  parameter int              ROW_W    = 16,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4B1D_0C57
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             tdi,
  input  logic [IR_W-1:0]  ir_q,
  input  logic             ir_lsb,
  input  logic             armed_q,
  input  logic [ROW_W-1:0] row_rdata,
  output logic [ROW_W-1:0] row_wdata,
  output logic             tdo,
  output logic             tdo_oe
);

  dr_sel_e          sel;
  logic             byp_q;
  logic [ID_W-1:0]  id_sr;
  logic [ROW_W-1:0] isp_sr;
  logic             cap_dr, sh_dr, verify_cap, dr_lsb;

  assign sel        = op_to_sel(ir_q);
  assign cap_dr     = (state == ST_CAP_DR);
  assign sh_dr      = (state == ST_SH_DR);
  assign verify_cap = cap_dr && armed_q && (ir_q == OP_VERIFY);
  assign row_wdata  = isp_sr;

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_sr[0];
      SEL_ISP: dr_lsb = isp_sr[0];
      default: dr_lsb = byp_q;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      isp_sr <= '0;
    end else begin
      if (sel == SEL_BYP) begin
        if (cap_dr)     byp_q <= 1'b0;
        else if (sh_dr) byp_q <= tdi;
      end
      if (sel == SEL_ID) begin
        if (cap_dr)     id_sr <= ID_VALUE;
        else if (sh_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
      if (sel == SEL_ISP) begin
        if (verify_cap) isp_sr <= row_rdata;
        else if (sh_dr) isp_sr <= {tdi, isp_sr[ROW_W-1:1]};
      end
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_IR) || sh_dr;
      if (state == ST_SH_IR) tdo <= ir_lsb;
      else if (sh_dr)        tdo <= dr_lsb;
    end
  end

  p_oe_in_shift_r6: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> ((state == ST_SH_IR) || (state == ST_SH_DR)));
  p_verify_capture_r11: assert property (@(posedge tck) disable iff (!rst_n)
    verify_cap |=> (isp_sr == $past(row_rdata)));
  p_capture_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr && sel == SEL_ISP && !verify_cap) |=> $stable(isp_sr));

endmodule

// File: rtl/tap_isp_port.sv
module tap_isp_port
  import tap_isp_pkg::*;
#(
  parameter int              ROW_W    = 16,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4B1D_0C57
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [ROW_W-1:0] row_rdata,
  output logic [ROW_W-1:0] row_wdata,
  output logic             erase_req,
  output logic             prog_req,
  output logic             verify_req
);

  logic [1:0]      rst_sync;
  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  logic            armed_q;
  logic [2:0]      req_q;

  // Asynchronous assertion, release aligned to TCK.
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .tdi     (tdi),
    .ir_q    (ir_q),
    .ir_lsb  (ir_lsb),
    .armed_q (armed_q),
    .req_q   (req_q)
  );

  tap_dr #(.ROW_W(ROW_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck       (tck),
    .rst_n     (rst_n),
    .state     (state),
    .tdi       (tdi),
    .ir_q      (ir_q),
    .ir_lsb    (ir_lsb),
    .armed_q   (armed_q),
    .row_rdata (row_rdata),
    .row_wdata (row_wdata),
    .tdo       (tdo),
    .tdo_oe    (tdo_oe)
  );

  assign erase_req  = req_q[0];
  assign prog_req   = req_q[1];
  assign verify_req = req_q[2];

endmodule

// File: tb/tap_isp_port_tb_top.sv
`timescale 1ns/1ps
module tap_isp_port_tb_top;

  localparam int          ROW_W = 16;
  localparam logic [31:0] IDV   = 32'h4B1D_0C57;

  logic tck = 1'b0;
  logic por_n, tms, tdi;
  logic tdo, tdo_oe, erase_req, prog_req, verify_req;
  logic [ROW_W-1:0] row_rdata, row_wdata;

  int n_vec = 0;
  int n_bad = 0;

  logic       s_tdo, s_oe;
  logic [2:0] s_req;

  always #4 tck = ~tck;

  tap_isp_port #(.ROW_W(ROW_W), .ID_VALUE(IDV)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .row_rdata(row_rdata), .row_wdata(row_wdata),
    .erase_req(erase_req), .prog_req(prog_req), .verify_req(verify_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Samples outputs before the coming rising edge, then drives TMS/TDI for it.
  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    s_tdo = tdo; s_oe = tdo_oe; s_req = {verify_req, prog_req, erase_req};
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic tms_reset_to_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle; ends in Run-Test/Idle (via Select-DR path if !direct).
  task automatic load_ir(input logic [3:0] code, input logic direct,
                         output logic [3:0] cap, output logic oe_all);
    step(1,0); step(1,0); step(0,0); step(0,0);
    oe_all = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      cap[i] = s_tdo;
      oe_all &= s_oe;
    end
    step(1,0);
    if (direct) step(0,0);
    else begin
      step(1,0); step(0,0); step(1,0); step(1,0); step(0,0);
    end
  endtask

  task automatic obs_strobe(output logic [2:0] during, output logic [2:0] after);
    step(0,0); step(0,0); during = s_req; step(0,0); after = s_req;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din,
                         output logic [63:0] dout, output logic oe_after);
    dout = '0;
    step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < n; i++) begin
      step(i == n-1, din[i]);
      dout[i] = s_tdo;
    end
    step(1,0); oe_after = s_oe;
    step(0,0);
  endtask

  task automatic por_pulse();
    @(negedge tck); por_n = 1'b0; tms = 1'b1;
    repeat (3) @(negedge tck);
    #1; chk("R1 tdo_oe in reset", tdo_oe, 0);
    chk("R1 strobes in reset", {verify_req, prog_req, erase_req}, 0);
    por_n = 1'b1;
    tms_reset_to_idle();
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0]  cap;
    logic        oe_all, oe_after;
    logic [2:0]  st_d, st_a;
    logic [63:0] dout;
    logic [15:0] p1, p2;

    por_n = 1'b0; tms = 1'b1; tdi = 1'b0; row_rdata = 16'hC3E1;
    por_pulse();

    // R1 / R4: identification instruction is active after reset
    scan_dr(32, 64'h0, dout, oe_after);
    chk("R1 R4 idcode after power-up", dout[31:0], IDV);
    chk("R6 oe low after shift", oe_after, 0);

    // Sweep all codes, unarmed
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code = c[3:0];
      tms_reset_to_idle();
      load_ir(code, 1'b1, cap, oe_all);
      chk("R3 IR capture 0001", cap, 4'b0001);
      chk("R6 oe high in Shift-IR", oe_all, 1);
      obs_strobe(st_d, st_a);
      chk("R10 no strobe unarmed", {st_d, st_a}, 0);
      if (code == 4'b0001) begin
        scan_dr(32, 64'h0, dout, oe_after);
        chk("R4 idcode shift", dout[31:0], IDV);
      end else if (code >= 4'b1001 && code <= 4'b1100) begin
        p1 = 16'h5A3C ^ {4{code}};
        p2 = ~p1;
        scan_dr(ROW_W, {48'h0, p1}, dout, oe_after);
        chk("R7 row_wdata after shift", row_wdata, p1);
        scan_dr(ROW_W, {48'h0, p2}, dout, oe_after);
        chk("R11 unarmed capture holds", dout[15:0], p1);
      end else begin
        scan_dr(8, 64'hA5, dout, oe_after);
        chk("R5 bypass delay", dout[7:0], 8'h4A);
      end
    end

    // Armed flow
    tms_reset_to_idle();
    load_ir(4'b1001, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R9 arm itself gives no strobe", {st_d, st_a}, 0);
    scan_dr(ROW_W, 64'h9D42, dout, oe_after);
    chk("R7 row data loaded", row_wdata, 16'h9D42);
    load_ir(4'b1011, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R9 program strobe", st_d, 3'b010);
    chk("R9 program strobe one cycle", st_a, 3'b000);
    chk("R7 row data at program", row_wdata, 16'h9D42);
    load_ir(4'b1010, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R8 R9 erase strobe while armed", {st_d, st_a}, {3'b001, 3'b000});
    row_rdata = 16'h3C7B;
    load_ir(4'b1100, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R9 verify strobe", {st_d, st_a}, {3'b100, 3'b000});
    scan_dr(ROW_W, 64'h0, dout, oe_after);
    chk("R11 verify capture", dout[15:0], 16'h3C7B);
    load_ir(4'b1111, 1'b1, cap, oe_all);
    load_ir(4'b1010, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R8 arming survives bypass", st_d, 3'b001);
    load_ir(4'b1010, 1'b0, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R9 no strobe via Select-DR exit", {st_d, st_a}, 0);

    // R2: TMS escape from Shift-DR clears arming and restores identification
    step(1,0); step(0,0); step(0,0);
    tms_reset_to_idle();
    scan_dr(32, 64'h0, dout, oe_after);
    chk("R2 idcode after TMS reset", dout[31:0], IDV);
    load_ir(4'b1010, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R2 arming cleared by TMS reset", {st_d, st_a}, 0);

    // R1: power-up reset clears arming
    load_ir(4'b1001, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    por_pulse();
    load_ir(4'b1010, 1'b1, cap, oe_all);
    obs_strobe(st_d, st_a);
    chk("R1 arming cleared by power-up reset", {st_d, st_a}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule